// File: doc/BRIEF.md
# EOI Interrupt-Storm Throttle

This block watches end-of-interrupt (EOI) events for level-triggered interrupt pins. When an EOI arrives for a pin whose line is still requesting and which is not masked, that pin normally has to be delivered again at once. If a pin keeps doing this back to back, its handler is probably not clearing the source. A counter for each pin tracks these successive re-deliveries. When a pin reaches the storm limit, the block stops re-delivering it immediately. Instead it starts one delay timer. When the timer expires, it walks all pins in order and asks the delivery path to send every level pin that is still requesting and has no delivery outstanding.

Two kinds of request leave the block. The first is an immediate re-delivery pulse, sent one cycle after a qualifying EOI. The second is a deferred rescan pulse, sent once per eligible pin while the sweep runs. The delivery path itself, including remote-IRR bookkeeping and the mask check at send time, lies outside the block.

Top module: `eoi_storm_throttle`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `now_vld` and `late_vld` are 0. Reset zeroes every pin counter and cancels any running delay or sweep.
- R2: A level EOI (`eoi_valid`=1, `eoi_level`=1) on a pin p with `pin_req[p]`=1 and `pin_mask[p]`=0 increments p's counter. If the new count is below `STORM_LIMIT`, the next cycle shows `now_vld`=1 with `now_pin`=p.
- R3: The level EOI that brings p's count to `STORM_LIMIT` produces no `now_vld`. It sets p's counter to 0 and, if the sequencer is idle, starts the delay.
- R4: A level EOI on a pin that is masked (`pin_mask[p]`=1) or not requesting (`pin_req[p]`=0) produces no `now_vld` and sets that pin's counter to 0.
- R5: An EOI with `eoi_level`=0 is ignored: it produces no pulse and leaves every counter unchanged.
- R6: The delay starts with the threshold EOI sampled at edge k. During the sweep, pin i is examined at edge k+`DELAY_CYCLES`+1+i, for pins in ascending order from 0 to `N_PINS`-1. After that edge, `late_vld`=1 with `late_pin`=i exactly when `pin_level[i]`=1, `pin_req[i]`=1 and `remote_irr[i]`=0 as sampled at that edge.
- R7: A threshold EOI that arrives while a delay or sweep is in progress is absorbed. It neither restarts the timer nor produces any pulse, although that pin's counter is still zeroed.
- R8: After the sweep has examined the last pin, the sequencer returns to idle. A later threshold then starts a fresh delay.
- R9: Counters are kept separately for each pin. An EOI on one pin never changes another pin's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_valid | input | 1 | An EOI event is presented this cycle |
| eoi_level | input | 1 | 1 = the EOI is for a level-triggered interrupt |
| eoi_pin | input | PIN_W | Pin the EOI refers to |
| pin_req | input | N_PINS | Line request state for each pin |
| pin_mask | input | N_PINS | Mask state for each pin |
| pin_level | input | N_PINS | 1 = the pin is configured level-triggered |
| remote_irr | input | N_PINS | 1 = a delivery is outstanding for the pin |
| now_vld | output | 1 | Immediate re-delivery pulse |
| now_pin | output | PIN_W | Pin for the immediate re-delivery |
| late_vld | output | 1 | Deferred delivery pulse emitted during the sweep |
| late_pin | output | PIN_W | Pin for the deferred delivery |

## Verification
Every result has a fixed latency. The immediate pulse appears one cycle after the EOI is sampled. The deferred pulse for pin i appears `DELAY_CYCLES`+1+i cycles after the threshold EOI. Inputs change only on falling edges. A cycle-level model in the bench updates on the same rising edge the design samples. Both outputs are compared against that model on every following falling edge, so each result is checked in exactly the cycle it is due, and early or late pulses show up as mismatches. The bench uses a short delay and a small limit, so storms, absorption and repeated sweeps all fit into one run.

// File: rtl/eoi_storm_pkg.sv
package eoi_storm_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_SCAN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/storm_counter_bank.sv
// Per-pin successive-EOI counters with threshold detection.
module storm_counter_bank #(
  parameter int N_PINS      = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int PIN_W       = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoi_valid,
  input  logic              eoi_level,
  input  logic [PIN_W-1:0]  eoi_pin,
  input  logic [N_PINS-1:0] pin_req,
  input  logic [N_PINS-1:0] pin_mask,
  output logic              go_now,
  output logic              hit_limit
);
  localparam int CW = $clog2(STORM_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(STORM_LIMIT);

  logic [CW-1:0] cnt_q [N_PINS];
  logic          lvl_eoi;
  logic          live;
  logic [CW-1:0] bumped;

  always_comb begin
    lvl_eoi   = eoi_valid && eoi_level;
    live      = lvl_eoi && pin_req[eoi_pin] && !pin_mask[eoi_pin];
    bumped    = cnt_q[eoi_pin] + CW'(1);
    hit_limit = live && (bumped == LIM);
    go_now    = live && (bumped != LIM);
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[i] <= '0;
      end else if (lvl_eoi && (eoi_pin == PIN_W'(i))) begin
        if (go_now) cnt_q[i] <= bumped;
        else        cnt_q[i] <= '0;
      end
    end
  end
endmodule

// File: rtl/storm_delay_seq.sv
// Delay timer followed by an ascending one-pin-per-cycle rescan.
module storm_delay_seq
  import eoi_storm_pkg::*;
#(
  parameter int N_PINS       = 8,
  parameter int DELAY_CYCLES = 2500000,
  parameter int PIN_W        = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_PINS-1:0] pin_req,
  input  logic [N_PINS-1:0] pin_level,
  input  logic [N_PINS-1:0] remote_irr,
  output logic              late_vld,
  output logic [PIN_W-1:0]  late_pin
);
  localparam int TW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [TW-1:0]    T_LAST = TW'(DELAY_CYCLES - 1);
  localparam logic [PIN_W-1:0] P_LAST = PIN_W'(N_PINS - 1);

  seq_state_t       st_q;
  logic [TW-1:0]    tmr_q;
  logic [PIN_W-1:0] idx_q;
  logic             elig;

  always_comb elig = pin_level[idx_q] && pin_req[idx_q] && !remote_irr[idx_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SEQ_IDLE;
      tmr_q    <= '0;
      idx_q    <= '0;
      late_vld <= 1'b0;
      late_pin <= '0;
    end else begin
      late_vld <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (start) begin
            st_q  <= SEQ_WAIT;
            tmr_q <= '0;
          end
        end
        SEQ_WAIT: begin
          if (tmr_q == T_LAST) begin
            st_q  <= SEQ_SCAN;
            idx_q <= '0;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        SEQ_SCAN: begin
          late_vld <= elig;
          late_pin <= idx_q;
          if (idx_q == P_LAST) st_q <= SEQ_IDLE;
          else                 idx_q <= idx_q + PIN_W'(1);
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle #(
  parameter int N_PINS       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DELAY_CYCLES = 2500000,
  parameter int PIN_W        = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoi_valid,
  input  logic              eoi_level,
  input  logic [PIN_W-1:0]  eoi_pin,
  input  logic [N_PINS-1:0] pin_req,
  input  logic [N_PINS-1:0] pin_mask,
  input  logic [N_PINS-1:0] pin_level,
  input  logic [N_PINS-1:0] remote_irr,
  output logic              now_vld,
  output logic [PIN_W-1:0]  now_pin,
  output logic              late_vld,
  output logic [PIN_W-1:0]  late_pin
);
  logic go_now;
  logic hit_limit;

  storm_counter_bank #(
    .N_PINS(N_PINS), .STORM_LIMIT(STORM_LIMIT), .PIN_W(PIN_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_level(eoi_level),
    .eoi_pin(eoi_pin), .pin_req(pin_req), .pin_mask(pin_mask),
    .go_now(go_now), .hit_limit(hit_limit)
  );

  // Start is ignored by the sequencer unless idle (absorption, R7).
  storm_delay_seq #(
    .N_PINS(N_PINS), .DELAY_CYCLES(DELAY_CYCLES), .PIN_W(PIN_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(hit_limit), .pin_req(pin_req),
    .pin_level(pin_level), .remote_irr(remote_irr),
    .late_vld(late_vld), .late_pin(late_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      now_vld <= 1'b0;
      now_pin <= '0;
    end else begin
      now_vld <= go_now;
      now_pin <= eoi_pin;
    end
  end
endmodule

// File: rtl/eoi_storm_checker.sv
module eoi_storm_checker #(
  parameter int N_PINS = 8,
  parameter int PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              eoi_valid,
  input logic              eoi_level,
  input logic [PIN_W-1:0]  eoi_pin,
  input logic [N_PINS-1:0] pin_req,
  input logic [N_PINS-1:0] pin_mask,
  input logic [N_PINS-1:0] pin_level,
  input logic [N_PINS-1:0] remote_irr,
  input logic              now_vld,
  input logic [PIN_W-1:0]  now_pin,
  input logic              late_vld,
  input logic [PIN_W-1:0]  late_pin
);
  // R2: immediate pulse names the pin of the EOI seen one cycle earlier
  p_now_pin_r2: assert property (@(posedge clk) disable iff (rst)
    now_vld |-> (now_pin == $past(eoi_pin)));

  // R4: masked pin never re-delivered immediately
  p_masked_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && eoi_level && pin_mask[eoi_pin]) |=> !now_vld);

  // R5: edge EOIs produce nothing
  p_edge_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !eoi_level) |=> !now_vld);

  // R6: deferred pulse only for an eligible pin, in ascending order
  p_late_elig_r6: assert property (@(posedge clk) disable iff (rst)
    late_vld |-> ((($past(pin_level & pin_req & ~remote_irr)) >> late_pin) & 1) != 0);

  p_late_order_r6: assert property (@(posedge clk) disable iff (rst)
    (late_vld && $past(late_vld)) |-> (late_pin == $past(late_pin) + PIN_W'(1)));
endmodule

bind eoi_storm_throttle eoi_storm_checker #(.N_PINS(N_PINS), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_level(eoi_level),
  .eoi_pin(eoi_pin), .pin_req(pin_req), .pin_mask(pin_mask),
  .pin_level(pin_level), .remote_irr(remote_irr), .now_vld(now_vld),
  .now_pin(now_pin), .late_vld(late_vld), .late_pin(late_pin)
);

// File: tb/eoi_storm_throttle_test.sv
module eoi_storm_throttle_test;
  localparam int N     = 8;
  localparam int PW    = 3;
  localparam int LIMIT = 12;
  localparam int DLY   = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          eoi_valid = 1'b0, eoi_level = 1'b0;
  logic [PW-1:0] eoi_pin = '0;
  logic [N-1:0]  pin_req = '0, pin_mask = '0, pin_level = '0, remote_irr = '0;
  logic          now_vld, late_vld;
  logic [PW-1:0] now_pin, late_pin;

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // reference model state
  int cnt [N];
  int m_st = 0, m_tmr = 0, m_idx = 0;
  logic m_now = 0, m_late = 0;
  int m_now_pin = 0, m_late_pin = 0;

  always #2 clk = ~clk;

  eoi_storm_throttle #(.N_PINS(N), .STORM_LIMIT(LIMIT), .DELAY_CYCLES(DLY)) uut (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_level(eoi_level),
    .eoi_pin(eoi_pin), .pin_req(pin_req), .pin_mask(pin_mask),
    .pin_level(pin_level), .remote_irr(remote_irr), .now_vld(now_vld),
    .now_pin(now_pin), .late_vld(late_vld), .late_pin(late_pin)
  );

  function automatic logic late_elig(int i);
    return pin_level[i] && pin_req[i] && !remote_irr[i];
  endfunction

  always @(posedge clk) begin
    int st0;
    logic hit;
    cycles++;
    if (rst) begin
      for (int i = 0; i < N; i++) cnt[i] = 0;
      m_st = 0; m_tmr = 0; m_idx = 0; m_now = 0; m_late = 0;
    end else begin
      st0 = m_st; hit = 0; m_now = 0; m_late = 0;
      if (eoi_valid && eoi_level) begin
        if (pin_req[eoi_pin] && !pin_mask[eoi_pin]) begin
          if (cnt[eoi_pin] + 1 == LIMIT) begin cnt[eoi_pin] = 0; hit = 1; end
          else begin cnt[eoi_pin]++; m_now = 1; m_now_pin = eoi_pin; end
        end else cnt[eoi_pin] = 0;
      end
      if (st0 == 1) begin
        if (m_tmr == DLY - 1) begin m_st = 2; m_idx = 0; end else m_tmr++;
      end else if (st0 == 2) begin
        m_late = late_elig(m_idx); m_late_pin = m_idx;
        if (m_idx == N - 1) m_st = 0; else m_idx++;
      end else if (hit) begin
        m_st = 1; m_tmr = 0;
      end
    end
  end

  task automatic check();
    vectors++;
    if (now_vld !== m_now || (m_now && now_pin !== PW'(m_now_pin)) ||
        late_vld !== m_late || (m_late && late_pin !== PW'(m_late_pin))) begin
      errors++;
      $display("FAIL %s: now=%b/%0d late=%b/%0d expected now=%b/%0d late=%b/%0d",
               tag, now_vld, now_pin, late_vld, late_pin,
               m_now, m_now_pin, m_late, m_late_pin);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check();
  endtask

  task automatic eoi(int p, logic lvl);
    eoi_valid = 1; eoi_level = lvl; eoi_pin = PW'(p);
    cyc();
    eoi_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: outputs quiet in reset
    tag = "R1"; check();
    rst = 0;
    cyc();

    // random mix: R2 R4 R5 R9
    tag = "R2 R4 R5 R9 random";
    for (int k = 0; k < 600; k++) begin
      eoi_valid  = ($urandom_range(3) != 0);
      eoi_level  = ($urandom_range(4) != 0);
      eoi_pin    = PW'($urandom_range(N - 1));
      pin_req    = N'($urandom);
      pin_mask   = N'($urandom) & N'($urandom);
      pin_level  = N'($urandom);
      remote_irr = N'($urandom);
      cyc();
    end
    eoi_valid = 0;
    while (m_st != 0) cyc();

    // R5: edge EOI ignored and does not disturb a count
    pin_req = '1; pin_mask = '0; pin_level = '1; remote_irr = '0;
    tag = "R4 clear"; eoi(1, 1'b0); pin_mask[1] = 1; eoi(1, 1'b1); pin_mask[1] = 0;
    tag = "R5";
    for (int k = 0; k < LIMIT - 2; k++) begin eoi(1, 1'b1); eoi(1, 1'b0); end
    tag = "R2 last below limit"; eoi(1, 1'b1);
    // R4: masked EOI zeroes count, so LIMIT-1 more immediate pulses follow
    tag = "R4"; pin_mask[1] = 1; eoi(1, 1'b1); pin_mask[1] = 0;
    pin_req[1] = 0; eoi(1, 1'b1); pin_req[1] = 1;
    for (int k = 0; k < LIMIT - 1; k++) eoi(1, 1'b1);
    // R3: threshold hit -> no immediate pulse, delay starts
    tag = "R3"; eoi(1, 1'b1);
    // R7: another full storm on pin 2 during the delay is absorbed
    tag = "R7";
    for (int k = 0; k < LIMIT; k++) eoi(2, 1'b1);
    // R6: sweep with mixed eligibility
    tag = "R6"; remote_irr = 8'b0010_0100; pin_level = 8'b1111_1011;
    pin_req = 8'b1101_1111;
    while (m_st != 0) cyc();
    cyc(); cyc();
    // R9: interleaved pins keep separate counts
    tag = "R9"; pin_req = '1; pin_level = '1; remote_irr = '0;
    for (int k = 0; k < LIMIT - 1; k++) begin eoi(0, 1'b1); eoi(4, 1'b1); end
    // R8: fresh threshold after idle starts a new delay and sweep
    tag = "R8"; eoi(4, 1'b1);
    while (m_st != 0) cyc();
    cyc(); cyc();
    tag = "R8 second"; eoi(0, 1'b1);
    while (m_st != 0) cyc();
    cyc();
    // R1: reset mid-delay cancels everything
    tag = "R1 mid-delay";
    for (int k = 0; k < LIMIT; k++) eoi(6, 1'b1);
    cyc();
    rst = 1; cyc(); rst = 0;
    for (int k = 0; k < DLY + N + 4; k++) cyc();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL R1 watchdog: cycles=%0d expected below 150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule